// File: doc/BRIEF.md
# I2C Slave Address Recognizer with Dual Masked 7-bit and 10-bit Matching

This block decides whether the device is being addressed as an I2C slave. A bit-level shifter upstream assembles each received byte and pulses a strobe when the byte is complete. The recognizer also sees the start, repeated-start and stop events from the bus monitor. It looks only at address bytes: the first byte after a start, and the second byte of a 10-bit address. It does not handle data bytes.

Two own addresses are held at the same time: a 7-bit one and a 10-bit one. Each has its own enable and its own bit mask, where a mask bit of 1 removes that address bit from the comparison. A 7-bit match is reported at once. A 10-bit write header is acknowledged without an interrupt, and the following byte is compared with the low eight address bits. Once the 10-bit address has matched, a repeated start followed by a read header is accepted and raises an interrupt. An address-length flag reports which mode matched. With both enables low, the block never acknowledges, which suits a device used only as a master.

All decisions are registered. They appear on the outputs one clock after the byte strobe or bus event that caused them.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, ack_req, irq, addressed, dir_tx, len10 and bus_busy are all 0.
- R2: A start event sets bus_busy on the next clock. A stop event clears bus_busy and addressed on the next clock, and stop takes priority over a start in the same cycle.
- R3: With en7=1, if the first byte after a start has bits 7:1 equal to own7, then one cycle after byte_done: ack_req=1 for one cycle, irq=1 for one cycle, addressed=1, len10=0 and dir_tx=NOT bit 0 of the byte.
- R4: With en7=0, or when an unmasked bit of the first byte differs from own7, no ack_req and no irq are produced and addressed stays 0.
- R5: A mask bit of 1 in mask7 or mask10 makes the corresponding address bit a don't-care. The match condition is ((rx XOR own) AND NOT mask) == 0.
- R6: With en10=1, a first byte with bits 7:3 = 11110, bits 2:1 matching own10[9:8] under mask10[9:8], and bit 0 = 0 is a write header. It gives ack_req=1, dir_tx=1, irq=0 and leaves addressed at 0. A header whose upper bits differ is not acknowledged.
- R7: The byte that directly follows an accepted write header is compared with own10[7:0] under mask10[7:0]. On a match it gives ack_req=1, irq=1, addressed=1 and len10=1. On a mismatch it gives no acknowledge.
- R8: After a full 10-bit match, a repeated start followed by a matching header with bit 0 = 1 gives ack_req=1, irq=1, addressed=1, len10=1 and dir_tx=0. Without a prior 10-bit match, that header is not acknowledged.
- R9: With en7=0 and en10=0, no byte ever produces ack_req.
- R10: A byte that is not an address byte (a later byte in the transfer) produces no ack_req or irq and leaves addressed unchanged.
- R11: A stop erases the record of a prior 10-bit match, so a read header after a new start is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | Start or repeated-start detected (one-cycle pulse) |
| stop_evt | input | 1 | Stop detected (one-cycle pulse) |
| byte_done | input | 1 | rx_byte holds a complete received byte (one-cycle pulse) |
| rx_byte | input | 8 | Received byte, bit 0 last on the wire |
| en7 | input | 1 | Enable 7-bit own address |
| own7 | input | 7 | 7-bit own address |
| mask7 | input | 7 | 7-bit don't-care mask |
| en10 | input | 1 | Enable 10-bit own address |
| own10 | input | 10 | 10-bit own address |
| mask10 | input | 10 | 10-bit don't-care mask |
| ack_req | output | 1 | Acknowledge the byte just received (one-cycle pulse) |
| irq | output | 1 | Addressed-as-slave interrupt (one-cycle pulse) |
| addressed | output | 1 | Device is addressed as slave |
| dir_tx | output | 1 | Direction: inverse of the last address R/W bit |
| len10 | output | 1 | 1 when the 10-bit address matched, valid while addressed |
| bus_busy | output | 1 | Bus is between a start and a stop |

## Verification
The 7-bit path is tried with an exact write address, an exact read address, a one-bit mismatch and the same mismatch hidden by a mask bit. Together these separate the direction inversion, the equality compare and the effect of the mask. The 10-bit path is driven through a write header with a matching low byte, then a repeated start with a read header. This separates the silent header acknowledge from the interrupting full match and from the read-header recognition. Negative patterns follow: a low-byte mismatch, wrong header upper bits, a read header with no prior match, a read header after a stop, and all enables off. Each shows that acknowledges depend on the enable, the mask and the recorded 10-bit history, not on byte shape alone. A data byte equal to the own address checks that only address positions are compared.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  logic       en7,
  input  logic [6:0] own7,
  input  logic [6:0] mask7,
  input  logic       en10,
  input  logic [9:0] own10,
  input  logic [9:0] mask10,
  output logic       ack_req,
  output logic       irq,
  output logic       addressed,
  output logic       dir_tx,
  output logic       len10,
  output logic       bus_busy
);
  localparam logic [4:0] HDR_TAG = 5'b11110;

  logic first_byte;
  logic hdr_ok;
  logic was10;

  wire m7      = en7 && (((rx_byte[7:1] ^ own7) & ~mask7) == 7'd0);
  wire hdr_hit = en10 && (rx_byte[7:3] == HDR_TAG) &&
                 (((rx_byte[2:1] ^ own10[9:8]) & ~mask10[9:8]) == 2'd0);
  wire hdr_wr  = hdr_hit && !rx_byte[0];
  wire hdr_rd  = hdr_hit && rx_byte[0] && was10;
  wire lo_hit  = en10 && (((rx_byte ^ own10[7:0]) & ~mask10[7:0]) == 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_req    <= 1'b0;
      irq        <= 1'b0;
      addressed  <= 1'b0;
      dir_tx     <= 1'b0;
      len10      <= 1'b0;
      bus_busy   <= 1'b0;
      first_byte <= 1'b0;
      hdr_ok     <= 1'b0;
      was10      <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      irq     <= 1'b0;
      if (stop_evt) begin
        bus_busy   <= 1'b0;
        addressed  <= 1'b0;
        first_byte <= 1'b0;
        hdr_ok     <= 1'b0;
        was10      <= 1'b0;
      end else if (start_evt) begin
        bus_busy   <= 1'b1;
        first_byte <= 1'b1;
        hdr_ok     <= 1'b0;
        addressed  <= 1'b0;
      end else if (byte_done) begin
        first_byte <= 1'b0;
        hdr_ok     <= 1'b0;
        if (first_byte) begin
          if (hdr_wr) begin
            ack_req <= 1'b1;
            dir_tx  <= 1'b1;
            hdr_ok  <= 1'b1;
          end else if (hdr_rd) begin
            ack_req   <= 1'b1;
            irq       <= 1'b1;
            addressed <= 1'b1;
            len10     <= 1'b1;
            dir_tx    <= 1'b0;
          end else if (m7) begin
            ack_req   <= 1'b1;
            irq       <= 1'b1;
            addressed <= 1'b1;
            len10     <= 1'b0;
            dir_tx    <= ~rx_byte[0];
          end
        end else if (hdr_ok && lo_hit) begin
          ack_req   <= 1'b1;
          irq       <= 1'b1;
          addressed <= 1'b1;
          len10     <= 1'b1;
          was10     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic stop_evt,
  input logic byte_done,
  input logic en7,
  input logic en10,
  input logic ack_req,
  input logic irq,
  input logic addressed,
  input logic bus_busy
);
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(byte_done)); // R3
  AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ack_req); // R6
  AST_IRQ_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> addressed); // R7
  AST_NO_ACK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !$past(en7)) |-> $past(en10)); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> (!addressed && !bus_busy)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_evt) && !$past(stop_evt)) |-> bus_busy); // R2
endmodule

bind i2c_addr_match i2c_addr_match_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .byte_done(byte_done), .en7(en7), .en10(en10), .ack_req(ack_req),
  .irq(irq), .addressed(addressed), .bus_busy(bus_busy)
);

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_evt = 1'b0, stop_evt = 1'b0, byte_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic en7 = 1'b1, en10 = 1'b0;
  logic [6:0] own7 = 7'h2A, mask7 = 7'h00;
  logic [9:0] own10 = 10'h2B5, mask10 = 10'h000;
  logic ack_req, irq, addressed, dir_tx, len10, bus_busy;
  logic seen = 1'b0;
  int checks = 0, failures = 0;

  typedef struct {
    logic ack; logic irq; logic addr; logic dir; logic len; string req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  i2c_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_done(byte_done), .rx_byte(rx_byte), .en7(en7), .own7(own7),
    .mask7(mask7), .en10(en10), .own10(own10), .mask10(mask10),
    .ack_req(ack_req), .irq(irq), .addressed(addressed), .dir_tx(dir_tx),
    .len10(len10), .bus_busy(bus_busy)
  );

  always_ff @(posedge clk) seen <= byte_done;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seen) begin
      if (q.size() == 0) check(0, "R10", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(ack_req == e.ack, e.req, "ack_req", ack_req, e.ack);
        check(irq == e.irq, e.req, "irq", irq, e.irq);
        check(addressed == e.addr, e.req, "addressed", addressed, e.addr);
        if (e.ack) begin
          check(dir_tx == e.dir, e.req, "dir_tx", dir_tx, e.dir);
          if (e.addr) check(len10 == e.len, e.req, "len10", len10, e.len);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic a, input logic i,
                      input logic ad, input logic d, input logic l, input string req);
    exp_t e;
    e.ack = a; e.irq = i; e.addr = ad; e.dir = d; e.len = l; e.req = req;
    q.push_back(e);
    @(negedge clk); rx_byte = b; byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); start_evt = 1'b1;
    @(negedge clk); start_evt = 1'b0;
    check(bus_busy == 1'b1, "R2", "bus_busy after start", bus_busy, 1);
  endtask

  task automatic do_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
    check(bus_busy == 1'b0, "R2", "bus_busy after stop", bus_busy, 0);
    check(addressed == 1'b0, "R2", "addressed after stop", addressed, 0);
  endtask

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({ack_req, irq, addressed, dir_tx, len10, bus_busy} == 6'b0, "R1",
          "outputs after reset", {ack_req, irq, addressed, dir_tx, len10, bus_busy}, 0);
    // 7-bit write, then data byte equal to own address
    do_start();
    send(8'h54, 1, 1, 1, 1, 0, "R3");
    send(8'h54, 0, 0, 1, 1, 0, "R10");
    do_stop();
    do_start();
    send(8'h55, 1, 1, 1, 0, 0, "R3");
    do_stop();
    do_start();
    send(8'h56, 0, 0, 0, 0, 0, "R4");
    do_stop();
    mask7 = 7'h01;
    do_start();
    send(8'h56, 1, 1, 1, 1, 0, "R5");
    do_stop();
    mask7 = 7'h00; en7 = 1'b0;
    do_start();
    send(8'h54, 0, 0, 0, 0, 0, "R4");
    do_stop();
    // 10-bit path
    en7 = 1'b1; en10 = 1'b1;
    do_start();
    send(8'hF4, 1, 0, 0, 1, 0, "R6");
    send(8'hB5, 1, 1, 1, 1, 1, "R7");
    do_start();
    send(8'hF5, 1, 1, 1, 0, 1, "R8");
    do_stop();
    do_start();
    send(8'hF4, 1, 0, 0, 1, 0, "R6");
    send(8'hB4, 0, 0, 0, 0, 0, "R7");
    do_start();
    send(8'hF5, 0, 0, 0, 0, 0, "R8");
    do_stop();
    mask10 = 10'h001;
    do_start();
    send(8'hF4, 1, 0, 0, 1, 0, "R6");
    send(8'hB4, 1, 1, 1, 1, 1, "R5");
    do_stop();
    do_start();
    send(8'hF5, 0, 0, 0, 0, 0, "R11");
    do_stop();
    mask10 = 10'h000;
    do_start();
    send(8'hF2, 0, 0, 0, 0, 0, "R6");
    do_stop();
    en7 = 1'b0; en10 = 1'b0;
    do_start();
    send(8'h54, 0, 0, 0, 0, 0, "R9");
    do_start();
    send(8'hF4, 0, 0, 0, 0, 0, "R9");
    do_stop();
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R10", "pending responses", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule